// File: doc/BRIEF.md
# Dual Capture/Compare Timer

The block holds two identical timer channels behind one small synchronous register port. Each channel has a control word, a load/capture register and a running count. A channel counts up or down from a value that software preloads. In compare mode, when the count wraps past its terminal value, the channel raises an event. It then either reloads from the load register or freezes at the terminal value. In capture mode, a rising edge on the channel's external capture pin copies the running count into the load register. Depending on the reload bit, later edges either overwrite that value or leave it alone until software acknowledges the event.

Each channel keeps a sticky event flag in its control word. Software clears the flag by writing a one to it. The flag drives a maskable interrupt pin. A one-clock generate pulse marks each compare wrap. An enable-all bit in either control word starts both channels together.

Each channel is sequenced by a four-state machine:
- ST_STOP: idle.
- ST_LOAD: the count follows the load register.
- ST_RUN: counting.
- ST_HOLD: frozen after a wrap with reload off.

The transitions are:
- stop-to-run when the channel is enabled.
- run-to-stop when it is disabled.
- any-state-to-load while the load bit is set.
- load-to-run or load-to-stop when the load bit drops, according to the enable.
- run-to-hold on a compare wrap with reload off.
- hold-to-load, which is the only exit from hold.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads zero and `irq` and `gen_out` are low.
- R2: Channel n occupies byte addresses 16n..16n+15. Word offset 0 is control, 4 is load/capture and 8 is the count; offset 12 reads zero. Control bits 0..11 read back as written, except that bit 8 is the event flag. Writes to offset 8 are ignored. Bits 9 and 11 are stored but have no effect.
- R3: While control bit 5 (load) is set, the count takes the load register value on every edge. Counting begins on the second edge after the write that enables the channel.
- R4: With control bit 7 (enable) set, the count steps by +1 when control bit 1 is 0, and by -1 when bit 1 is 1.
- R5: In compare mode (bit 0 = 0) with bit 4 (reload) set, a step from all ones while counting up, or from zero while counting down, loads the count from the load register and sets the flag (bit 8).
- R6: In compare mode with bit 4 clear, that wrap sets the flag once and freezes the count at the terminal value until the load bit is set.
- R7: With bit 2 set, `gen_out[n]` is high for exactly the one cycle after each compare wrap.
- R8: In capture mode (bit 0 = 1) with bit 3 set, a rising edge of `cap_in[n]` is passed through two flops. The third edge after `cap_in` rises copies into the load register the count as it stood after the second edge, and sets the flag. The count keeps running and wraps without raising events.
- R9: In capture mode with bit 4 clear and the flag set, further captures leave the load register unchanged; once the flag is cleared, captures resume. With bit 4 set, every capture overwrites the register.
- R10: Writing control with bit 8 = 1 clears the flag. Writing bit 8 = 0 leaves it unchanged. An event in the same cycle wins.
- R11: `irq[n]` is high exactly while the flag and bit 6 of channel n are both set.
- R12: Bit 10 set in either control word runs both channels, whatever their own enable bits say. With no enable, a channel's count stays still.
- R13: With bit 3 clear, `cap_in` edges change neither the load register nor the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_addr | input | 5 | Byte address; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| gen_out | output | 2 | One-cycle compare-wrap pulses |
| irq | output | 2 | Interrupt per channel |

## Verification
The read path is combinational, so a register written on edge W reads back in the low phase after W. The count first moves on edge W+2, so after k edges it has taken k-1 steps. The flag and the generate pulse appear on the very edge of the wrap. A capture lands three edges after `cap_in` rises, holding the count that was present after the second. The bench drives on falling edges and reads in the low phase. It computes counts, flags and pulse totals from the step index k-1 and the wrap period (2^32-L when counting up, L+1 when counting down). It predicts each captured value as the count read at the moment `cap_in` rises, plus or minus two.

// File: rtl/twt_pkg.sv
package twt_pkg;
    // control word bit positions
    localparam int CTRL_W    = 12;
    localparam int CB_CAPT   = 0;
    localparam int CB_DOWN   = 1;
    localparam int CB_GEN    = 2;
    localparam int CB_CAPEN  = 3;
    localparam int CB_RELOAD = 4;
    localparam int CB_LOAD   = 5;
    localparam int CB_IE     = 6;
    localparam int CB_EN     = 7;
    localparam int CB_FLAG   = 8;
    localparam int CB_ALL    = 10;

    // address window per channel: 16 bytes
    localparam int WIN_BITS = 4;
    localparam logic [1:0] OFF_CTRL  = 2'd0;
    localparam logic [1:0] OFF_LOAD  = 2'd1;
    localparam logic [1:0] OFF_COUNT = 2'd2;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/twt_capsync.sv
module twt_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/twt_stepper.sv
module twt_stepper #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             down_i,
    output logic [CNT_W-1:0] next_o,
    output logic             term_o
);
    always_comb begin
        if (down_i) begin
            next_o = cnt_i - CNT_W'(1);
            term_o = (cnt_i == '0);
        end else begin
            next_o = cnt_i + CNT_W'(1);
            term_o = &cnt_i;
        end
    end
endmodule

// File: rtl/twt_channel.sv
module twt_channel
    import twt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              run_all,
    input  logic              cap_raw,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [1:0]        state_o,
    output logic              gen_o,
    output logic              irq_o
);
    tmr_state_e        state_q, state_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  load_q, cnt_q, cnt_step;
    logic              gen_q;
    logic              at_term, cap_rise;
    logic              run, ld, step_ok, cmp_event, cap_fire, evt;

    twt_capsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cap_raw),
        .rise_o  (cap_rise)
    );

    twt_stepper #(.CNT_W(CNT_W)) u_step (
        .cnt_i  (cnt_q),
        .down_i (ctrl_q[CB_DOWN]),
        .next_o (cnt_step),
        .term_o (at_term)
    );

    assign run       = ctrl_q[CB_EN] | run_all;
    assign ld        = ctrl_q[CB_LOAD];
    assign step_ok   = (state_q == ST_RUN) && run && !ld;
    assign cmp_event = step_ok && at_term && !ctrl_q[CB_CAPT];
    assign cap_fire  = ctrl_q[CB_CAPT] && ctrl_q[CB_CAPEN] && cap_rise
                       && (ctrl_q[CB_RELOAD] || !ctrl_q[CB_FLAG]);
    assign evt       = cmp_event | cap_fire;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (ld)       state_d = ST_LOAD;
                else if (run) state_d = ST_RUN;
            end
            ST_LOAD: begin
                if (!ld) state_d = run ? ST_RUN : ST_STOP;
            end
            ST_RUN: begin
                if (ld)                                   state_d = ST_LOAD;
                else if (!run)                            state_d = ST_STOP;
                else if (cmp_event && !ctrl_q[CB_RELOAD]) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (ld) state_d = ST_LOAD;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            cnt_q  <= '0;
            gen_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q          <= wdata[CTRL_W-1:0];
                ctrl_q[CB_FLAG] <= (ctrl_q[CB_FLAG] & ~wdata[CB_FLAG]) | evt;
            end else if (evt) begin
                ctrl_q[CB_FLAG] <= 1'b1;
            end

            if (cap_fire)     load_q <= cnt_q;
            else if (wr_load) load_q <= wdata[CNT_W-1:0];

            if (ld) begin
                cnt_q <= load_q;
            end else if (step_ok) begin
                if (cmp_event) cnt_q <= ctrl_q[CB_RELOAD] ? load_q : cnt_q;
                else           cnt_q <= cnt_step;
            end

            gen_q <= cmp_event & ctrl_q[CB_GEN];
        end
    end

    assign ctrl_o  = ctrl_q;
    assign load_o  = load_q;
    assign count_o = cnt_q;
    assign state_o = state_q;
    assign gen_o   = gen_q;
    assign irq_o   = ctrl_q[CB_FLAG] & ctrl_q[CB_IE];
endmodule

// File: rtl/twin_timer.sv
module twin_timer
    import twt_pkg::*;
#(
    parameter int N_TMR       = 2,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (N_TMR > 1) ? $clog2(N_TMR) : 1,
    localparam int ADDR_W     = SEL_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_TMR-1:0]  cap_in,
    output logic [N_TMR-1:0]  gen_out,
    output logic [N_TMR-1:0]  irq
);
    logic [SEL_W-1:0]                addr_sel;
    logic [1:0]                      addr_off;
    logic                            unused_byte_bits;
    logic [N_TMR-1:0]                wr_ctrl, wr_load, all_bits;
    logic                            run_all;
    logic [N_TMR-1:0][CTRL_W-1:0]    ctrl_all;
    logic [N_TMR-1:0][CNT_W-1:0]     load_all;
    logic [N_TMR-1:0][CNT_W-1:0]     count_all;
    logic [N_TMR-1:0][1:0]           state_all;

    assign addr_sel         = reg_addr[ADDR_W-1:WIN_BITS];
    assign addr_off         = reg_addr[WIN_BITS-1:2];
    assign unused_byte_bits = ^reg_addr[1:0];
    assign run_all          = |all_bits;

    for (genvar g = 0; g < N_TMR; g++) begin : g_chan
        assign wr_ctrl[g]  = reg_wr && (addr_sel == SEL_W'(g)) && (addr_off == OFF_CTRL);
        assign wr_load[g]  = reg_wr && (addr_sel == SEL_W'(g)) && (addr_off == OFF_LOAD);
        assign all_bits[g] = ctrl_all[g][CB_ALL];

        twt_channel #(
            .CNT_W       (CNT_W),
            .DATA_W      (DATA_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl[g]),
            .wr_load (wr_load[g]),
            .wdata   (reg_wdata),
            .run_all (run_all),
            .cap_raw (cap_in[g]),
            .ctrl_o  (ctrl_all[g]),
            .load_o  (load_all[g]),
            .count_o (count_all[g]),
            .state_o (state_all[g]),
            .gen_o   (gen_out[g]),
            .irq_o   (irq[g])
        );
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (addr_sel == SEL_W'(i)) begin
                case (addr_off)
                    OFF_CTRL:  reg_rdata = DATA_W'(ctrl_all[i]);
                    OFF_LOAD:  reg_rdata = DATA_W'(load_all[i]);
                    OFF_COUNT: reg_rdata = DATA_W'(count_all[i]);
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
    import twt_pkg::*;
#(
    parameter int N_TMR  = 2,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_wr,
    input logic [ADDR_W-3:0]            win_addr,
    input logic                         flag_wr_bit,
    input logic [N_TMR-1:0]             gen_out,
    input logic [N_TMR-1:0][CTRL_W-1:0] ctrl_all,
    input logic [N_TMR-1:0][CNT_W-1:0]  load_all,
    input logic [N_TMR-1:0][CNT_W-1:0]  count_all,
    input logic [N_TMR-1:0][1:0]        state_all
);
    localparam int SEL_W = ADDR_W - WIN_BITS;

    logic run_any;
    always_comb begin
        run_any = 1'b0;
        for (int i = 0; i < N_TMR; i++) run_any = run_any | ctrl_all[i][CB_ALL];
    end

    for (genvar g = 0; g < N_TMR; g++) begin : g_chk
        logic hit_ctrl, hit_load;
        assign hit_ctrl = reg_wr && (win_addr[ADDR_W-3:WIN_BITS-2] == SEL_W'(g))
                          && (win_addr[WIN_BITS-3:0] == OFF_CTRL);
        assign hit_load = reg_wr && (win_addr[ADDR_W-3:WIN_BITS-2] == SEL_W'(g))
                          && (win_addr[WIN_BITS-3:0] == OFF_LOAD);

        assert_load_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_all[g][CB_LOAD] |=> count_all[g] == $past(load_all[g]));

        assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (state_all[g] == ST_HOLD) && !ctrl_all[g][CB_LOAD] |=> $stable(count_all[g]));

        assert_gen_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
            gen_out[g] |-> ctrl_all[g][CB_FLAG]);

        assert_capture_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_all[g][CB_CAPT] && !ctrl_all[g][CB_RELOAD] && ctrl_all[g][CB_FLAG] && !hit_load
            |=> $stable(load_all[g]));

        assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_all[g][CB_FLAG] && !(hit_ctrl && flag_wr_bit) |=> ctrl_all[g][CB_FLAG]);

        assert_idle_still_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_all[g][CB_EN] && !run_any && !ctrl_all[g][CB_LOAD] |=> $stable(count_all[g]));
    end
endmodule

bind twin_timer twin_timer_chk #(
    .N_TMR  (N_TMR),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .win_addr    (reg_addr[ADDR_W-1:2]),
    .flag_wr_bit (reg_wdata[twt_pkg::CB_FLAG]),
    .gen_out     (gen_out),
    .ctrl_all    (ctrl_all),
    .load_all    (load_all),
    .count_all   (count_all),
    .state_all   (state_all)
);

// File: tb/twin_timer_test.sv
module twin_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  cap_in = '0;
    logic [1:0]  gen_out, irq;
    int          n_chk = 0, n_err = 0, gen_cnt0 = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    twin_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cap_in    (cap_in),
        .gen_out   (gen_out),
        .irq       (irq)
    );

    always @(posedge clk) begin
        #1;
        if (gen_out[0]) gen_cnt0++;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic longint unsigned period(input logic [31:0] l, input bit dn);
        return dn ? (64'(l) + 64'd1) : (64'h1_0000_0000 - 64'(l));
    endfunction

    function automatic logic [31:0] exp_count(input logic [31:0] l, input bit dn, input bit ar, input int j);
        longint unsigned p = period(l, dn);
        longint unsigned jj = longint'(j);
        if (ar) return dn ? l - 32'(jj % p) : l + 32'(jj % p);
        if (jj < p) return dn ? l - 32'(jj) : l + 32'(jj);
        return dn ? 32'h0 : 32'hFFFF_FFFF;
    endfunction

    function automatic int exp_wraps(input logic [31:0] l, input bit dn, input bit ar, input int j);
        longint unsigned p = period(l, dn);
        longint unsigned jj = longint'(j);
        if (ar) return int'(jj / p);
        return (jj >= p) ? 1 : 0;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete got=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v1, v2, c;
        ticks(3);
        rst_n = 1'b1;
        ticks(1);

        // R1: reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk($sformatf("R1 reset read addr=%0d", a), v, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset gen_out", 32'(gen_out), 32'h0);

        // R2: map, readback, count read-only, inert bits
        wr(5'h10, 32'h0000_0A00);
        rd(5'h10, v); chk("R2 ctrl1 readback", v, 32'h0000_0A00);
        wr(5'h14, 32'h1234_5678);
        rd(5'h14, v); chk("R2 load1 readback", v, 32'h1234_5678);
        rd(5'h04, v); chk("R2 load0 untouched", v, 32'h0);
        wr(5'h18, 32'hDEAD_BEEF);
        rd(5'h18, v); chk("R2 count write ignored", v, 32'h0);
        rd(5'h1C, v); chk("R2 offset 12 zero", v, 32'h0);
        ticks(3);
        rd(5'h18, v); chk("R2 inert bits leave count still", v, 32'h0);

        // R3 R4 R5 R6 R7 R11: compare sweep on channel 0
        for (int dn = 0; dn < 2; dn++) begin
            for (int ar = 0; ar < 2; ar++) begin
                for (int li = 0; li < 3; li++) begin
                    for (int k = 1; k <= 7; k++) begin
                        automatic logic [31:0] base = (li == 2) ? 32'd3 : 32'(li);
                        automatic logic [31:0] l = (dn != 0) ? base : ~base;
                        automatic logic [31:0] cfg = 32'h0000_00C4 | 32'(dn << 1) | 32'(ar << 4);
                        automatic int j = k - 1;
                        automatic bit fl = (longint'(j) >= period(l, dn != 0));
                        wr(5'h00, 32'h0);
                        wr(5'h04, l);
                        wr(5'h00, 32'h0000_0120);
                        wr(5'h00, cfg);
                        gen_cnt0 = 0;
                        ticks(k);
                        rd(5'h08, v);
                        chk($sformatf("R3 R4 R5 R6 count dn=%0d ar=%0d L=%h k=%0d", dn, ar, l, k),
                            v, exp_count(l, dn != 0, ar != 0, j));
                        rd(5'h00, v);
                        chk($sformatf("R5 R6 flag dn=%0d ar=%0d L=%h k=%0d", dn, ar, l, k),
                            32'(v[8]), 32'(fl));
                        chk($sformatf("R11 irq dn=%0d ar=%0d L=%h k=%0d", dn, ar, l, k),
                            32'(irq[0]), 32'(fl));
                        chk($sformatf("R7 gen pulses dn=%0d ar=%0d L=%h k=%0d", dn, ar, l, k),
                            32'(gen_cnt0), 32'(exp_wraps(l, dn != 0, ar != 0, j)));
                    end
                end
            end
        end

        // R8 R9: capture sweep on channel 0
        for (int dn = 0; dn < 2; dn++) begin
            for (int ar = 0; ar < 2; ar++) begin
                automatic logic [31:0] cfg = 32'h0000_00C9 | 32'(dn << 1) | 32'(ar << 4);
                wr(5'h00, 32'h0);
                wr(5'h04, 32'd1000);
                wr(5'h00, 32'h0000_0120);
                wr(5'h00, cfg);
                ticks(2);
                rd(5'h08, v1);
                cap_in[0] = 1'b1;
                ticks(4);
                rd(5'h04, c);
                chk($sformatf("R8 first capture dn=%0d ar=%0d", dn, ar), c, dn ? v1 - 32'd2 : v1 + 32'd2);
                rd(5'h00, v);
                chk($sformatf("R8 capture flag dn=%0d ar=%0d", dn, ar), 32'(v[8]), 32'h1);
                cap_in[0] = 1'b0;
                ticks(3);
                rd(5'h08, v2);
                cap_in[0] = 1'b1;
                ticks(4);
                rd(5'h04, c);
                chk($sformatf("R9 second capture dn=%0d ar=%0d", dn, ar), c,
                    (ar != 0) ? (dn ? v2 - 32'd2 : v2 + 32'd2) : (dn ? v1 - 32'd2 : v1 + 32'd2));
                cap_in[0] = 1'b0;
                if (ar == 0) begin
                    wr(5'h00, cfg | 32'h100);
                    ticks(2);
                    rd(5'h08, v2);
                    cap_in[0] = 1'b1;
                    ticks(4);
                    rd(5'h04, c);
                    chk($sformatf("R9 capture after ack dn=%0d", dn), c, dn ? v2 - 32'd2 : v2 + 32'd2);
                    cap_in[0] = 1'b0;
                end
                ticks(3);
            end
        end

        // R13: capture input disabled
        wr(5'h00, 32'h0);
        wr(5'h04, 32'd1000);
        wr(5'h00, 32'h0000_0120);
        wr(5'h00, 32'h0000_00C1);
        ticks(2);
        cap_in[0] = 1'b1;
        ticks(5);
        rd(5'h04, c); chk("R13 load unchanged", c, 32'd1000);
        rd(5'h00, v); chk("R13 flag clear", 32'(v[8]), 32'h0);
        cap_in[0] = 1'b0;

        // R10 R11 R6: flag handling on a held compare
        wr(5'h00, 32'h0);
        wr(5'h04, 32'hFFFF_FFFE);
        wr(5'h00, 32'h0000_0120);
        wr(5'h00, 32'h0000_00C0);
        ticks(6);
        rd(5'h00, v); chk("R6 held flag set", 32'(v[8]), 32'h1);
        chk("R11 irq high", 32'(irq[0]), 32'h1);
        wr(5'h00, 32'h0000_00C0);
        rd(5'h00, v); chk("R10 write zero keeps flag", 32'(v[8]), 32'h1);
        wr(5'h00, 32'h0000_0080);
        chk("R11 irq masked", 32'(irq[0]), 32'h0);
        rd(5'h00, v); chk("R11 flag kept while masked", 32'(v[8]), 32'h1);
        wr(5'h00, 32'h0000_0180);
        rd(5'h00, v); chk("R10 write one clears flag", 32'(v[8]), 32'h0);
        rd(5'h08, v); chk("R6 count frozen at terminal", v, 32'hFFFF_FFFF);

        // R12: enable-all from channel 0 runs channel 1
        wr(5'h14, 32'd50);
        wr(5'h10, 32'h0000_0020);
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h0000_0400);
        ticks(5);
        rd(5'h18, v); chk("R12 channel1 runs via enable-all", v, 32'd54);
        wr(5'h00, 32'h0);
        rd(5'h18, v1);
        ticks(4);
        rd(5'h18, v2); chk("R12 channel1 stops without enable", v2, v1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule